// File: doc/BRIEF.md
# Interrupt Trigger Configuration and Sensing

This block keeps the two-bit trigger setting of every interrupt handled by an interrupt distributor and converts raw interrupt lines into one pending flag per interrupt. Interrupts fall into three classes. Software-generated interrupts (IDs 0 to 15) are fixed as edge-triggered. Private peripheral interrupts (IDs 16 to 31) are fixed as level-sensitive, and only IDs 25 to 31 have input lines. Shared peripheral interrupts (IDs 32 and up) have one programmable bit that selects level sensing or rising-edge sensing.

Software reaches the settings through a small register port. The port takes a word address, a write enable and 32-bit write data, and it returns read data one cycle later. Each word packs sixteen two-bit fields. A fixed identification word sits at the highest address. Each raw line passes through a two-flop synchronizer and is turned active-high before it is sensed. A downstream consumer clears edge-captured pending flags with a per-interrupt acknowledge strobe.

Top module: `irq_trig_cfg`

## Requirements
- R1: After reset every pending flag is 0, read data is 0, and every shared trigger bit is 0, which selects level sensing.
- R2: Word address 0 (IDs 0..15) always reads 0xAAAAAAAA, so each field reads 2'b10. Writes to it change nothing.
- R3: Word address 1 (IDs 16..31) always reads 0x55540000. Fields for IDs 16..24 read 2'b00 and fields for IDs 25..31 read 2'b01. Writes to it change nothing.
- R4: Word address 2+k holds shared IDs 32+16k..47+16k. The field of ID n sits at bits [2(n mod 16)+1 : 2(n mod 16)] and reads {trigger bit, 1}. A write stores only the odd bits of the data, and the even bits are ignored.
- R5: The highest word address (2^ADDR_W-1) reads 0x0000043B, and writes to it change nothing. Every other address outside words 0..1+NUM_SHARED/16 reads 0.
- R6: Read data is registered. The value of the word addressed in cycle t appears in cycle t+1 and reflects the state before any write made in cycle t.
- R7: Private line i (i = 0..6) drives pending bit 25+i. Lines 0..5 are active-low and line 6 is active-high. The pending bit follows the line with three cycles of latency, and acknowledges have no effect on it.
- R8: A shared interrupt whose trigger bit is 0 has a pending bit that follows its raw line with three cycles of latency, and acknowledges have no effect on it.
- R9: A shared interrupt whose trigger bit is 1 sets its pending bit three cycles after a 0-to-1 change of its raw line. The bit stays set until the acknowledge for that ID, which clears it at the next edge.
- R10: If a new rising edge is detected in the same cycle as an acknowledge for that ID, the pending bit stays set.
- R11: Pending bits for IDs 0..24 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word address of the register port |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| ppi_raw | input | 7 | Raw private interrupt lines, mixed polarity |
| spi_raw | input | NUM_SHARED | Raw shared interrupt lines, active-high |
| irq_ack | input | 32+NUM_SHARED | Per-ID acknowledge strobes |
| irq_pending | output | 32+NUM_SHARED | Per-ID pending flags |

## Verification
A trigger bit stored in the wrong place shows up at the ports in two ways. On the next read of its word, a field at the wrong position or with the wrong value appears. On the next raw transition of that line, the pending flag either follows the line where it should latch or latches where it should follow. A wrong synchronizer or edge-history state moves the pending flag away from the three-cycle window, so it is visible in the first cycle after the line changes. A lost acknowledge or a lost set leaves a pending bit disagreeing with the requirement-derived model within one cycle. The bench therefore compares the full pending vector and the read data on every cycle of random traffic. Directed sequences place an acknowledge exactly on the edge-detect cycle.

// File: rtl/irq_trig_pkg.sv
`timescale 1ns/1ps
package irq_trig_pkg;
  localparam int          WORD_W        = 32;
  localparam int          FIELDS_PER_W  = 16;
  localparam int          PRIV_LINES    = 7;
  localparam int          PRIV_FIRST_ID = 25;
  localparam int          SHARED_BASE   = 32;
  localparam logic [1:0]  CFG_SOFT      = 2'b10;
  localparam logic [1:0]  CFG_PRIV      = 2'b01;
  localparam logic [6:0]  PRIV_LOW_MASK = 7'b011_1111;
  localparam logic [31:0] IDENT_WORD    = {8'h00, 4'h0, 4'h0, 4'h0, 12'h43B};

  typedef enum logic [1:0] {
    WC_SOFT   = 2'd0,
    WC_PRIV   = 2'd1,
    WC_SHARED = 2'd2,
    WC_OTHER  = 2'd3
  } word_class_e;

  // Spread a 16-bit set of trigger bits into a packed config word.
  function automatic logic [31:0] expand_shared(input logic [15:0] msb);
    logic [31:0] r;
    for (int k = 0; k < FIELDS_PER_W; k++) begin
      r[2*k]   = 1'b1;
      r[2*k+1] = msb[k];
    end
    return r;
  endfunction

  function automatic logic [15:0] odd_bits(input logic [31:0] w);
    logic [15:0] r;
    for (int k = 0; k < FIELDS_PER_W; k++) r[k] = w[2*k+1];
    return r;
  endfunction

  function automatic logic [31:0] fixed_word(input logic [1:0] code, input int first, input int last);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < FIELDS_PER_W; k++)
      if (k >= first && k <= last) r[2*k +: 2] = code;
    return r;
  endfunction
endpackage

// File: rtl/irq_sync2.sv
`timescale 1ns/1ps
module irq_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  // R8: the synchronized output is the input two edges earlier
  p_sync_delay_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> sync_q == $past(meta_q));
endmodule

// File: rtl/irq_sense.sv
`timescale 1ns/1ps
module irq_sense #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] rise;

  assign rise = sync_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                 pend_q[i] <= 1'b0;
      else if (edge_mode_i[i]) pend_q[i] <= rise[i] | (pend_q[i] & ~ack_i[i]);
      else                     pend_q[i] <= sync_i[i];
    end
  end

  assign pend_o = pend_q;

  // R8: level lanes copy the synchronized line one edge later
  p_level_follow_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend_q ^ $past(sync_i)) & ~$past(edge_mode_i)) == '0);

  // R9: an edge-captured flag without acknowledge is held
  p_edge_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pend_q & $past(edge_mode_i & pend_q & ~ack_i)) == $past(edge_mode_i & pend_q & ~ack_i));

  // R10: a new edge wins over a simultaneous acknowledge
  p_edge_beats_ack_r10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pend_q & $past(edge_mode_i & rise & ack_i)) == $past(edge_mode_i & rise & ack_i));
endmodule

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
  import irq_trig_pkg::*;
#(
  parameter int NUM_SHARED = 32,
  parameter int ADDR_W     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [31:0]           wdata_i,
  output logic [NUM_SHARED-1:0] edge_mode_o,
  output logic [31:0]           rdata_o
);
  localparam int          SH_WORDS   = NUM_SHARED / FIELDS_PER_W;
  localparam int          FIRST_SH   = 2;
  localparam logic [ADDR_W-1:0] ID_ADDR = {ADDR_W{1'b1}};
  localparam logic [31:0] SOFT_WORD  = fixed_word(CFG_SOFT, 0, 15);
  localparam logic [31:0] PRIV_WORD  = fixed_word(CFG_PRIV, PRIV_FIRST_ID - 16, 15);

  initial begin
    if (NUM_SHARED % FIELDS_PER_W != 0) $error("NUM_SHARED must be a multiple of 16");
    if (FIRST_SH + SH_WORDS >= (1 << ADDR_W)) $error("ADDR_W too small");
  end

  for (genvar w = 0; w < SH_WORDS; w++) begin : g_word
    logic [15:0] msb_q;
    always_ff @(posedge clk) begin
      if (rst) msb_q <= '0;
      else if (we_i && addr_i == ADDR_W'(FIRST_SH + w)) msb_q <= odd_bits(wdata_i);
    end
    assign edge_mode_o[w*FIELDS_PER_W +: FIELDS_PER_W] = msb_q;
  end

  word_class_e      cls;
  logic [ADDR_W-1:0] sh_idx;
  logic [31:0]      rd_next;
  logic [31:0]      rdata_q;

  always_comb begin
    sh_idx = addr_i - ADDR_W'(FIRST_SH);
    if (addr_i == '0)                                            cls = WC_SOFT;
    else if (addr_i == ADDR_W'(1))                               cls = WC_PRIV;
    else if (addr_i >= ADDR_W'(FIRST_SH) && 32'(sh_idx) < SH_WORDS) cls = WC_SHARED;
    else                                                         cls = WC_OTHER;
  end

  always_comb begin
    unique case (cls)
      WC_SOFT:   rd_next = SOFT_WORD;
      WC_PRIV:   rd_next = PRIV_WORD;
      WC_SHARED: rd_next = expand_shared(edge_mode_o[32'(sh_idx)*FIELDS_PER_W +: FIELDS_PER_W]);
      default:   rd_next = (addr_i == ID_ADDR) ? IDENT_WORD : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;

  // R2: software-generated word is fixed
  p_soft_word_r2: assert property (@(posedge clk) disable iff (rst)
    addr_i == '0 |=> rdata_o == 32'hAAAA_AAAA);
  // R3: private word is fixed
  p_priv_word_r3: assert property (@(posedge clk) disable iff (rst)
    addr_i == ADDR_W'(1) |=> rdata_o == 32'h5554_0000);
  // R5: identification word
  p_ident_r5: assert property (@(posedge clk) disable iff (rst)
    addr_i == ID_ADDR |=> rdata_o == 32'h0000_043B);
  // R4: shared fields always read with the low bit set
  p_shared_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    cls == WC_SHARED |=> (rdata_o & 32'h5555_5555) == 32'h5555_5555);
endmodule

// File: rtl/irq_trig_cfg.sv
`timescale 1ns/1ps
module irq_trig_cfg
  import irq_trig_pkg::*;
#(
  parameter int NUM_SHARED = 32,
  parameter int ADDR_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_we,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [PRIV_LINES-1:0]    ppi_raw,
  input  logic [NUM_SHARED-1:0]    spi_raw,
  input  logic [SHARED_BASE+NUM_SHARED-1:0] irq_ack,
  output logic [SHARED_BASE+NUM_SHARED-1:0] irq_pending
);
  localparam int SYNC_W = NUM_SHARED + PRIV_LINES;

  logic [NUM_SHARED-1:0] edge_mode;
  logic [PRIV_LINES-1:0] priv_norm;
  logic [SYNC_W-1:0]     sync_out;
  logic [PRIV_LINES-1:0] priv_pend;
  logic [NUM_SHARED-1:0] sh_pend;

  irq_cfg_regs #(.NUM_SHARED(NUM_SHARED), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr_i(reg_addr), .we_i(reg_we), .wdata_i(reg_wdata),
    .edge_mode_o(edge_mode), .rdata_o(reg_rdata)
  );

  // Normalize polarity ahead of synchronization so reset value means idle.
  assign priv_norm = ppi_raw ^ PRIV_LOW_MASK;

  irq_sync2 #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .d_i({spi_raw, priv_norm}), .q_o(sync_out)
  );

  irq_sense #(.W(PRIV_LINES)) u_priv (
    .clk(clk), .rst(rst), .sync_i(sync_out[PRIV_LINES-1:0]),
    .edge_mode_i('0), .ack_i(irq_ack[PRIV_FIRST_ID +: PRIV_LINES]), .pend_o(priv_pend)
  );

  irq_sense #(.W(NUM_SHARED)) u_shared (
    .clk(clk), .rst(rst), .sync_i(sync_out[SYNC_W-1:PRIV_LINES]),
    .edge_mode_i(edge_mode), .ack_i(irq_ack[SHARED_BASE +: NUM_SHARED]), .pend_o(sh_pend)
  );

  assign irq_pending = {sh_pend, priv_pend, {PRIV_FIRST_ID{1'b0}}};

  // R11: no pending flag below the first private line
  p_low_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    irq_pending[PRIV_FIRST_ID-1:0] == '0);
  // R7: private lanes never latch, so they track their line
  p_priv_level_r7: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq_pending[SHARED_BASE-1:PRIV_FIRST_ID] == $past(sync_out[PRIV_LINES-1:0]));
endmodule

// File: tb/sim_irq_trig_cfg.sv
`timescale 1ns/1ps
module sim_irq_trig_cfg;
  localparam int NS = 32;
  localparam int AW = 6;
  localparam int NI = 32 + NS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_d = '0;
  logic          we_d = 1'b0;
  logic [31:0]   wdata_d = '0;
  logic [31:0]   rdata;
  logic [6:0]    ppi_d = 7'b011_1111;
  logic [NS-1:0] spi_d = '0;
  logic [NI-1:0] ack_d = '0;
  logic [NI-1:0] pend;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // requirement-level model state
  logic [NS-1:0] m_edge, sh_s1, sh_s2, sh_prev, m_psh;
  logic [6:0]    pv_s1, pv_s2, m_ppv;
  logic [31:0]   m_rd;

  always #2 clk = ~clk;

  irq_trig_cfg #(.NUM_SHARED(NS), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .reg_addr(addr_d), .reg_we(we_d), .reg_wdata(wdata_d),
    .reg_rdata(rdata), .ppi_raw(ppi_d), .spi_raw(spi_d), .irq_ack(ack_d), .irq_pending(pend)
  );

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 0) r = 32'hAAAA_AAAA;
    else if (a == 1) r = 32'h5554_0000;
    else if (a == 2 || a == 3) begin
      for (int k = 0; k < 16; k++) begin
        r[2*k] = 1'b1;
        r[2*k+1] = m_edge[(int'(a) - 2) * 16 + k];
      end
    end else if (a == {AW{1'b1}}) r = 32'h0000_043B;
    return r;
  endfunction

  function automatic logic [NI-1:0] exp_pend();
    return {m_psh, m_ppv, 25'b0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_edge = '0; sh_s1 = '0; sh_s2 = '0; sh_prev = '0; m_psh = '0;
    pv_s1 = '0; pv_s2 = '0; m_ppv = '0; m_rd = '0;
  endtask

  task automatic tick();
    logic [NS-1:0] nps;
    @(posedge clk);
    m_rd = exp_word(addr_d);
    for (int j = 0; j < NS; j++)
      nps[j] = m_edge[j] ? ((sh_s2[j] & ~sh_prev[j]) | (m_psh[j] & ~ack_d[32+j])) : sh_s2[j];
    m_psh = nps;
    m_ppv = pv_s2;
    sh_prev = sh_s2; sh_s2 = sh_s1; sh_s1 = spi_d;
    pv_s2 = pv_s1;   pv_s1 = ppi_d ^ 7'b011_1111;
    if (we_d && (addr_d == 2 || addr_d == 3))
      for (int k = 0; k < 16; k++) m_edge[(int'(addr_d) - 2) * 16 + k] = wdata_d[2*k+1];
    @(negedge clk);
  endtask

  task automatic compare_all();
    logic [NI-1:0] e;
    e = exp_pend();
    chk("R6 read data", 64'(rdata), 64'(m_rd));
    chk("R11 low pending", 64'(pend[24:0]), 64'(e[24:0]));
    chk("R7 private pending", 64'(pend[31:25]), 64'(e[31:25]));
    chk("R8/R9 shared pending", 64'(pend[NI-1:32]), 64'(e[NI-1:32]));
  endtask

  task automatic step();
    tick();
    compare_all();
  endtask

  task automatic idle_reg();
    we_d = 1'b0; addr_d = 6'd10; wdata_d = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 pending after reset", 64'(pend), 64'd0);
    chk("R1 rdata after reset", 64'(rdata), 64'd0);
    addr_d = 6'd2; step();
    chk("R1 shared word reset", 64'(rdata), 64'h5555_5555);

    // R2 / R3 / R5: writes to fixed words ignored, read back
    addr_d = 6'd0; we_d = 1; wdata_d = 32'h0; step();
    we_d = 0; step();
    chk("R2 soft word after write", 64'(rdata), 64'hAAAA_AAAA);
    addr_d = 6'd1; we_d = 1; wdata_d = 32'hFFFF_FFFF; step();
    we_d = 0; step();
    chk("R3 private word after write", 64'(rdata), 64'h5554_0000);
    addr_d = 6'd63; we_d = 1; wdata_d = 32'h1234_5678; step();
    we_d = 0; step();
    chk("R5 ident word", 64'(rdata), 64'h0000_043B);
    addr_d = 6'd20; step();
    chk("R5 unmapped word", 64'(rdata), 64'd0);

    // R4 / R6: only odd bits stored; same-cycle read returns old value
    addr_d = 6'd3; we_d = 1; wdata_d = 32'h5555_000A; step();
    chk("R6 old value on write cycle", 64'(rdata), 64'h5555_5555);
    we_d = 0; step();
    chk("R4 odd bits only", 64'(rdata), 64'h5555_555F);

    // R9 / R10 directed on ID 32
    addr_d = 6'd2; we_d = 1; wdata_d = 32'h0000_0002; step();
    idle_reg();
    spi_d[0] = 1'b1; step(); step(); step();
    chk("R9 edge sets pending", 64'(pend[32]), 64'd1);
    spi_d[0] = 1'b0; step(); step(); step(); step();
    chk("R9 pending held after line falls", 64'(pend[32]), 64'd1);
    spi_d[0] = 1'b1; step(); step();
    ack_d[32] = 1'b1; step();
    chk("R10 edge and ack same cycle", 64'(pend[32]), 64'd1);
    step();
    chk("R9 ack clears pending", 64'(pend[32]), 64'd0);
    ack_d[32] = 1'b0; step();

    // R8: level mode ignores ack (ID 33)
    spi_d[1] = 1'b1; step(); step(); step();
    ack_d[33] = 1'b1; step();
    chk("R8 level ignores ack", 64'(pend[33]), 64'd1);
    ack_d[33] = 1'b0; spi_d[1] = 1'b0; step(); step(); step();
    chk("R8 level follows line low", 64'(pend[33]), 64'd0);

    // R7: private polarity, line 0 active-low, line 6 active-high
    ppi_d = 7'b111_1110; step(); step(); step();
    chk("R7 private polarity", 64'(pend[31:25]), 64'b100_0001);
    ppi_d = 7'b011_1111; step(); step(); step();
    chk("R7 private idle", 64'(pend[31:25]), 64'd0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int sel;
      sel = $urandom_range(0, 7);
      case (sel)
        0: addr_d = 6'd0;
        1: addr_d = 6'd1;
        2, 3: addr_d = 6'd2;
        4: addr_d = 6'd3;
        5: addr_d = 6'd63;
        default: addr_d = AW'($urandom);
      endcase
      we_d    = ($urandom_range(0, 9) == 0);
      wdata_d = $urandom;
      spi_d   = spi_d ^ (NS'($urandom) & NS'($urandom) & NS'($urandom));
      if ($urandom_range(0, 3) == 0) ppi_d = ppi_d ^ (7'($urandom) & 7'($urandom));
      ack_d   = {NI{1'b0}} | (NI'({$urandom, $urandom}) & NI'({$urandom, $urandom}));
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule